// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Transmitter

This block sends asynchronous serial frames from a one-byte holding register that sits in front of a frame shift register. Software, or a neighbouring controller, writes a byte through a simple write strobe. If the shifter is idle and the transmitter is enabled, the byte moves straight into the shifter. Otherwise it waits in the holding register. The shifter reloads from the holding register when it finishes a frame, so frames follow each other with no idle gap as long as the holding register is refilled before the current frame ends.

Two status outputs tell the writer what it may do. A buffer-empty interrupt flag means the holding register can take another byte. A shifter-empty status means the line has nothing left to send. The bit rate comes from an 8-bit divisor and a speed-range select. A separate enable for the whole serial port gates everything, and clearing either that enable or the transmit enable abandons the frame in flight.

Top module: `dbuf_uart_tx`

## Requirements
- R1: After reset the line output is 1, the shifter-empty status is 1, the buffer-empty flag is 0 and the transmit enable is 0.
- R2: Writing a byte clears the buffer-empty flag. If, at that edge, the shifter is empty, the transmit enable is 1, the port enable is 1 and no byte is waiting, the byte enters the shifter on the same edge. Shifter-empty then reads 0 and the flag reads 1 one cycle later.
- R3: A frame is a 0 start bit, then the 8 data bits least significant first, then (only when nine-bit mode was set at load time) the ninth-bit control value, then a 1 stop bit. That makes 10 or 11 bit times.
- R4: Every bit lasts (N+1)*16 clocks with the high-speed select at 1 and (N+1)*64 clocks with it at 0, where N is the divisor value. Writing the divisor restarts the bit-period count.
- R5: The line changes only on a bit-period boundary. When a byte is loaded into an idle shifter, the start bit appears at the next boundary. After a divisor write at edge E0, that boundary is edge E0+(N+1)*prescale.
- R6: A byte waiting in the holding register loads when the stop bit of the current frame begins, so its start bit follows that stop bit with no gap. The buffer-empty flag sets on that load.
- R7: Shifter-empty sets when a stop bit begins with no byte waiting. While shifter-empty is 1 the line is 1.
- R8: Clearing the transmit enable abandons the frame. One edge after the control write takes effect, the line is 1 and shifter-empty is 1, and the abandoned byte is never resent.
- R9: The buffer-empty flag sets when the port enable rises while the transmit enable is 1, and when the transmit enable rises while the port enable is 1. It does not set on either rise while the other enable is 0.
- R10: While the port enable is 0, the line is 1, the frame in flight is abandoned, the buffer-empty flag is 0 and nothing is sent. A byte written in that time waits and goes out once the port enable returns.
- R11: A byte written while the transmit enable is 0 stays in the holding register with no line activity. It is sent, with the control settings current at load time, once the transmit enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| port_en | input | 1 | Serial port enable |
| wr_data_en | input | 1 | Holding-register write strobe |
| wr_data | input | 8 | Byte to send |
| wr_ctrl_en | input | 1 | Control write strobe |
| ctrl_tx_en | input | 1 | Transmit enable value |
| ctrl_nine | input | 1 | Nine-bit frame mode value |
| ctrl_bit8 | input | 1 | Ninth data bit value |
| ctrl_hi_speed | input | 1 | 1 selects the x16 prescale, 0 the x64 prescale |
| wr_div_en | input | 1 | Divisor write strobe |
| wr_div | input | 8 | Divisor value N |
| tx_o | output | 1 | Serial line output |
| buf_empty_irq | output | 1 | Holding register can accept a byte |
| shift_empty | output | 1 | Shift register has nothing to send |

## Verification
Stimulus is applied on falling clock edges. Each result is read on the first falling edge at which the design could show it. A load or a flag change after a byte write is due one edge later. An abort after a control write is due two edges later, because the enable is registered first. After a divisor write at edge E0 and a byte write at E1, the line must still be high after edge E0+P-1 and low after E0+P. The first data edge must come exactly P clocks after that. Frames are sampled mid-bit every P clocks from the first falling line edge, so a missing or extra clock anywhere in a frame, or a gap between back-to-back frames, shifts later samples and shows up as a miscompare.

// File: rtl/dbuf_uart_tx_pkg.sv
package dbuf_uart_tx_pkg;

   // Latched control fields; bit order is internal only.
   typedef struct packed {
      logic hi_speed;
      logic bit8;
      logic nine;
      logic tx_en;
   } tx_ctrl_t;

endpackage

// File: rtl/dbuf_uart_tx_baud.sv
module dbuf_uart_tx_baud #(
   parameter int DIV_W    = 8,
   parameter int HI_SHIFT = 4,
   parameter int LO_SHIFT = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             restart,
   input  logic             hi_speed,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   localparam int CNT_W = DIV_W + LO_SHIFT + 1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] base_w;
   logic [CNT_W-1:0] span_w;
   logic [CNT_W-1:0] limit_w;

   assign base_w  = CNT_W'(div) + CNT_W'(1);
   assign span_w  = hi_speed ? (base_w << HI_SHIFT) : (base_w << LO_SHIFT);
   assign limit_w = span_w - CNT_W'(1);
   assign tick    = run && (cnt_q == limit_w);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run || restart || tick)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + CNT_W'(1);
   end
endmodule

// File: rtl/dbuf_uart_tx_hold.sv
module dbuf_uart_tx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              take,
   input  logic              set_evt,
   input  logic              clr_evt,
   output logic [DATA_W-1:0] data_o,
   output logic              full_o,
   output logic              flag_o
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_o <= '0;
         full_o <= 1'b0;
         flag_o <= 1'b0;
      end else begin
         if (wr)
            data_o <= wr_data;

         // a take with an empty buffer consumes the write directly
         if (take)
            full_o <= full_o && wr;
         else if (wr)
            full_o <= 1'b1;

         if (clr_evt)
            flag_o <= 1'b0;
         else if (take)
            flag_o <= !(full_o && wr);
         else if (wr)
            flag_o <= 1'b0;
         else if (set_evt)
            flag_o <= 1'b1;
      end
   end
endmodule

// File: rtl/dbuf_uart_tx_shift.sv
module dbuf_uart_tx_shift #(
   parameter int DATA_W  = 8,
   parameter bit NINE_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              abort,
   input  logic              load,
   input  logic [DATA_W-1:0] ld_data,
   input  logic              ld_nine,
   input  logic              ld_bit8,
   output logic              tx_o,
   output logic              empty_o,
   output logic              done_o
);
   localparam int FW = DATA_W + 3;
   localparam int CW = $clog2(FW + 1);
   localparam logic [CW-1:0] LEN8 = CW'(DATA_W + 2);
   localparam logic [CW-1:0] LEN9 = CW'(DATA_W + 3);

   logic [FW-1:0] sh_q;
   logic [CW-1:0] cnt_q;
   logic [FW-1:0] frame_w;
   logic [CW-1:0] len_w;
   logic          busy_w;

   generate
      if (NINE_EN) begin : g_nine
         assign frame_w = ld_nine ? {1'b1, ld_bit8, ld_data, 1'b0}
                                  : {2'b11, ld_data, 1'b0};
         assign len_w   = ld_nine ? LEN9 : LEN8;
      end else begin : g_eight
         logic unused_cfg;
         assign unused_cfg = ld_nine ^ ld_bit8;
         assign frame_w    = {2'b11, ld_data, 1'b0};
         assign len_w      = LEN8;
      end
   endgenerate

   assign busy_w = (cnt_q != '0);
   assign done_o = tick && (cnt_q == CW'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q    <= '1;
         cnt_q   <= '0;
         tx_o    <= 1'b1;
         empty_o <= 1'b1;
      end else if (abort) begin
         cnt_q   <= '0;
         tx_o    <= 1'b1;
         empty_o <= 1'b1;
      end else begin
         if (tick && busy_w)
            tx_o <= sh_q[0];
         if (load) begin
            sh_q    <= frame_w;
            cnt_q   <= len_w;
            empty_o <= 1'b0;
         end else if (tick && busy_w) begin
            sh_q  <= {1'b1, sh_q[FW-1:1]};
            cnt_q <= cnt_q - CW'(1);
            if (cnt_q == CW'(1))
               empty_o <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/dbuf_uart_tx.sv
module dbuf_uart_tx #(
   parameter int DATA_W   = 8,
   parameter int DIV_W    = 8,
   parameter int HI_SHIFT = 4,
   parameter int LO_SHIFT = 6,
   parameter bit NINE_EN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              port_en,
   input  logic              wr_data_en,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              wr_ctrl_en,
   input  logic              ctrl_tx_en,
   input  logic              ctrl_nine,
   input  logic              ctrl_bit8,
   input  logic              ctrl_hi_speed,
   input  logic              wr_div_en,
   input  logic [DIV_W-1:0]  wr_div,
   output logic              tx_o,
   output logic              buf_empty_irq,
   output logic              shift_empty
);
   import dbuf_uart_tx_pkg::*;

   generate
      if (LO_SHIFT <= HI_SHIFT) begin : g_bad_prescale
         $error("low-speed prescale must exceed high-speed prescale");
      end
      if (DATA_W < 5 || DIV_W < 1) begin : g_bad_width
         $error("data or divisor width out of range");
      end
   endgenerate

   tx_ctrl_t          ctrl_q;
   logic [DIV_W-1:0]  div_q;
   logic              port_en_d;
   logic              tx_en_d;
   logic              tx_en_w;
   logic              abort_w;
   logic              baud_tick;
   logic              shift_done_w;
   logic              can_take_w;
   logic              load_w;
   logic              hold_full;
   logic [DATA_W-1:0] hold_data;
   logic [DATA_W-1:0] ld_data_w;
   logic              set_evt_w;
   logic              clr_evt_w;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_q    <= '0;
         div_q     <= '0;
         port_en_d <= 1'b0;
         tx_en_d   <= 1'b0;
      end else begin
         if (wr_ctrl_en) begin
            ctrl_q.tx_en    <= ctrl_tx_en;
            ctrl_q.nine     <= ctrl_nine;
            ctrl_q.bit8     <= ctrl_bit8;
            ctrl_q.hi_speed <= ctrl_hi_speed;
         end
         if (wr_div_en)
            div_q <= wr_div;
         port_en_d <= port_en;
         tx_en_d   <= ctrl_q.tx_en;
      end
   end

   assign tx_en_w    = ctrl_q.tx_en;
   assign abort_w    = !(tx_en_w && port_en);
   assign can_take_w = !abort_w && (shift_empty || shift_done_w);
   assign load_w     = can_take_w && (hold_full || wr_data_en);
   assign ld_data_w  = hold_full ? hold_data : wr_data;
   assign set_evt_w  = tx_en_w && port_en && (!port_en_d || !tx_en_d);
   assign clr_evt_w  = !port_en;

   dbuf_uart_tx_baud #(
      .DIV_W(DIV_W), .HI_SHIFT(HI_SHIFT), .LO_SHIFT(LO_SHIFT)
   ) u_baud (
      .clk(clk), .rst_n(rst_n), .run(port_en), .restart(wr_div_en),
      .hi_speed(ctrl_q.hi_speed), .div(div_q), .tick(baud_tick)
   );

   dbuf_uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk(clk), .rst_n(rst_n), .wr(wr_data_en), .wr_data(wr_data),
      .take(load_w), .set_evt(set_evt_w), .clr_evt(clr_evt_w),
      .data_o(hold_data), .full_o(hold_full), .flag_o(buf_empty_irq)
   );

   dbuf_uart_tx_shift #(.DATA_W(DATA_W), .NINE_EN(NINE_EN)) u_shift (
      .clk(clk), .rst_n(rst_n), .tick(baud_tick), .abort(abort_w),
      .load(load_w), .ld_data(ld_data_w), .ld_nine(ctrl_q.nine),
      .ld_bit8(ctrl_q.bit8), .tx_o(tx_o), .empty_o(shift_empty),
      .done_o(shift_done_w)
   );
endmodule

// File: rtl/dbuf_uart_tx_chk.sv
module dbuf_uart_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic port_en,
   input logic wr_data_en,
   input logic tx_en_w,
   input logic hold_full,
   input logic baud_tick,
   input logic abort_w,
   input logic tx_o,
   input logic shift_empty,
   input logic buf_empty_irq
);
   p_idle_line_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
      shift_empty |-> tx_o);

   p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_en_w |=> (shift_empty && tx_o));

   p_port_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !port_en |=> (!buf_empty_irq && tx_o));

   p_load_now_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_data_en && shift_empty && tx_en_w && port_en && !hold_full)
      |=> (!shift_empty && buf_empty_irq));

   p_line_on_tick_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tx_o) |-> ($past(baud_tick) || $past(abort_w)));
endmodule

bind dbuf_uart_tx dbuf_uart_tx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .port_en(port_en), .wr_data_en(wr_data_en),
   .tx_en_w(tx_en_w), .hold_full(hold_full), .baud_tick(baud_tick),
   .abort_w(abort_w), .tx_o(tx_o), .shift_empty(shift_empty),
   .buf_empty_irq(buf_empty_irq)
);

// File: tb/dbuf_uart_tx_tb_top.sv
module dbuf_uart_tx_tb_top;
   logic       clk = 1'b0;
   logic       rst_n, port_en, wr_data_en, wr_ctrl_en, wr_div_en;
   logic       ctrl_tx_en, ctrl_nine, ctrl_bit8, ctrl_hi_speed;
   logic [7:0] wr_data, wr_div;
   logic       tx_o, buf_empty_irq, shift_empty;
   int         vectors = 0;
   int         miscomp = 0;

   always #10 clk = ~clk;

   dbuf_uart_tx dut_i (
      .clk(clk), .rst_n(rst_n), .port_en(port_en), .wr_data_en(wr_data_en),
      .wr_data(wr_data), .wr_ctrl_en(wr_ctrl_en), .ctrl_tx_en(ctrl_tx_en),
      .ctrl_nine(ctrl_nine), .ctrl_bit8(ctrl_bit8), .ctrl_hi_speed(ctrl_hi_speed),
      .wr_div_en(wr_div_en), .wr_div(wr_div), .tx_o(tx_o),
      .buf_empty_irq(buf_empty_irq), .shift_empty(shift_empty)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (act !== exp) begin
         miscomp++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic pause(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr_ctrl(input logic te, input logic nine, input logic b8, input logic hi);
      ctrl_tx_en = te; ctrl_nine = nine; ctrl_bit8 = b8; ctrl_hi_speed = hi;
      wr_ctrl_en = 1'b1; pause(1); wr_ctrl_en = 1'b0;
   endtask

   task automatic wr_divisor(input logic [7:0] n);
      wr_div = n; wr_div_en = 1'b1; pause(1); wr_div_en = 1'b0;
   endtask

   task automatic wr_byte(input logic [7:0] d);
      wr_data = d; wr_data_en = 1'b1; pause(1); wr_data_en = 1'b0;
   endtask

   task automatic wait_idle(input int p);
      int guard = 0;
      while (!shift_empty && guard < 4000) begin pause(1); guard++; end
      pause(p);
   endtask

   task automatic capture(input int nbits, input int p, output logic [31:0] got,
                          output logic [31:0] got_se, output logic [31:0] got_fl);
      int guard = 0;
      got = '0; got_se = '0; got_fl = '0;
      while (tx_o !== 1'b0 && guard < 40 * p) begin pause(1); guard++; end
      pause(p / 2);
      for (int i = 0; i < nbits; i++) begin
         got[i] = tx_o; got_se[i] = shift_empty; got_fl[i] = buf_empty_irq;
         if (i != nbits - 1) pause(p);
      end
   endtask

   task automatic line_quiet(input string req, input int cycles);
      int lows = 0;
      for (int i = 0; i < cycles; i++) begin
         if (tx_o !== 1'b1) lows++;
         pause(1);
      end
      chk(req, lows, 0);
   endtask

   task automatic t_reset();
      chk("R1 line", tx_o, 1);
      chk("R1 shift_empty", shift_empty, 1);
      chk("R1 flag", buf_empty_irq, 0);
   endtask

   task automatic t_enable();
      wr_ctrl(1, 0, 0, 1); pause(1);
      chk("R9 tx_en rise with port off", buf_empty_irq, 0);
      port_en = 1'b1; pause(1);
      chk("R9 port rise sets flag", buf_empty_irq, 1);
      chk("R9 line idle", tx_o, 1);
      port_en = 1'b0; pause(1);
      chk("R10 port off clears flag", buf_empty_irq, 0);
      wr_ctrl(0, 0, 0, 1);
      port_en = 1'b1; pause(2);
      chk("R9 port rise with tx_en off", buf_empty_irq, 0);
      wr_ctrl(1, 0, 0, 1); pause(1);
      chk("R9 tx_en rise sets flag", buf_empty_irq, 1);
   endtask

   // R4 R5: start bit exactly P clocks after the divisor restart
   task automatic t_tick(input logic [7:0] n, input logic hi, input logic [7:0] d);
      int p = (int'(n) + 1) * (hi ? 16 : 64);
      wait_idle(130);
      wr_ctrl(1, 0, 0, hi);
      wr_divisor(n);
      wr_byte(d);
      chk("R2 immediate load", shift_empty, 0);
      chk("R2 flag after load", buf_empty_irq, 1);
      pause(p - 2);
      chk("R5 line high before boundary", tx_o, 1);
      pause(1);
      chk("R5 start bit on boundary", tx_o, 0);
      pause(p - 1);
      chk("R4 start bit still low", tx_o, 0);
      pause(1);
      chk("R4 first data bit after one period", tx_o, 1);
      wait_idle(p + 2);
   endtask

   task automatic t_frame(input logic nine, input logic b8, input logic [7:0] d);
      logic [31:0] got, se, fl, exp;
      int nb = nine ? 11 : 10;
      wait_idle(20);
      wr_ctrl(1, nine, b8, 1);
      wr_byte(d);
      capture(nb, 16, got, se, fl);
      exp = nine ? {21'd0, 1'b1, b8, d, 1'b0} : {22'd0, 1'b1, d, 1'b0};
      chk("R3 frame bits", got, exp);
      chk("R7 shift_empty at stop bit", se, 32'(1) << (nb - 1));
   endtask

   task automatic t_b2b(input logic [7:0] a, input logic [7:0] b);
      logic [31:0] got, se, fl;
      wait_idle(20);
      wr_ctrl(1, 0, 0, 1);
      wr_byte(a);
      wr_byte(b);
      chk("R2 write clears flag", buf_empty_irq, 0);
      chk("R2 shifter busy", shift_empty, 0);
      capture(20, 16, got, se, fl);
      chk("R6 two frames no gap", got, {12'd0, 1'b1, b, 1'b0, 1'b1, a, 1'b0});
      chk("R6 flag set on reload", fl, 32'h000FFE00);
      chk("R7 shift_empty only at last stop", se, 32'h00080000);
   endtask

   task automatic t_abort();
      wait_idle(20);
      wr_byte(8'h00);
      pause(3 * 16);
      wr_ctrl(0, 0, 0, 1);
      pause(1);
      chk("R8 shift_empty after abort", shift_empty, 1);
      chk("R8 line high after abort", tx_o, 1);
      line_quiet("R8 no further bits", 12 * 16);
      wr_ctrl(1, 0, 0, 1); pause(1);
      chk("R8 aborted byte not resent", shift_empty, 1);
      line_quiet("R8 line stays idle", 3 * 16);
   endtask

   task automatic t_port_off();
      logic [31:0] got, se, fl;
      wait_idle(20);
      wr_byte(8'h00);
      pause(3 * 16);
      port_en = 1'b0; pause(1);
      chk("R10 flag cleared", buf_empty_irq, 0);
      chk("R10 shift_empty after drop", shift_empty, 1);
      chk("R10 line high", tx_o, 1);
      wr_byte(8'hC3);
      chk("R10 write while off not loaded", shift_empty, 0 + 1);
      line_quiet("R10 nothing sent while off", 4 * 16);
      port_en = 1'b1; pause(1);
      chk("R10 waiting byte loads on enable", shift_empty, 0);
      chk("R10 flag on enable", buf_empty_irq, 1);
      capture(10, 16, got, se, fl);
      chk("R10 waiting byte frame", got, {22'd0, 1'b1, 8'hC3, 1'b0});
   endtask

   task automatic t_hold_disabled();
      logic [31:0] got, se, fl;
      wait_idle(20);
      wr_ctrl(0, 0, 0, 1);
      wr_byte(8'h5A);
      chk("R11 flag cleared by write", buf_empty_irq, 0);
      chk("R11 shifter stays empty", shift_empty, 1);
      line_quiet("R11 no line activity", 3 * 16);
      wr_ctrl(1, 1, 1, 1);
      pause(1);
      chk("R11 loads on enable", shift_empty, 0);
      chk("R11 flag on enable", buf_empty_irq, 1);
      capture(11, 16, got, se, fl);
      chk("R11 frame with load-time settings", got, {21'd0, 1'b1, 1'b1, 8'h5A, 1'b0});
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      miscomp++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0; port_en = 1'b0; wr_data_en = 1'b0; wr_ctrl_en = 1'b0;
      wr_div_en = 1'b0; ctrl_tx_en = 1'b0; ctrl_nine = 1'b0; ctrl_bit8 = 1'b0;
      ctrl_hi_speed = 1'b0; wr_data = '0; wr_div = '0;
      pause(3);
      rst_n = 1'b1;
      pause(1);
      t_reset();
      t_enable();
      t_tick(8'd0, 1'b1, 8'h35);
      t_tick(8'd1, 1'b0, 8'h01);
      t_tick(8'd2, 1'b1, 8'hFF);
      wait_idle(130);
      wr_ctrl(1, 0, 0, 1);
      wr_divisor(8'd0);
      t_frame(1'b0, 1'b0, 8'hA5);
      t_frame(1'b1, 1'b1, 8'h3C);
      t_frame(1'b1, 1'b0, 8'hFF);
      t_b2b(8'h81, 8'h7E);
      t_abort();
      t_port_off();
      t_hold_disabled();
      summary();
      $finish;
   end
endmodule